// File: doc/BRIEF.md
# CPU Status Flag Register

This block holds the eight condition and control flags of an 8-bit processor and computes their new values after each arithmetic or logic operation. The ALU hands it the operation's result, both operands, the carry out of bit 7 and the carry out of bit 3, together with an operation kind (logic, add or subtract). It also hands over a six-bit mask naming the flags that this operation may change. The block derives zero, negative, overflow and sign from these inputs and latches them on the next clock edge. Flags outside the mask keep their value.

Beside the ALU path, the register takes a single-bit transfer into its bit-copy flag, so that a bit can be stored from a general register and later loaded back into one. The interrupt-enable flag has its own commands: it is cleared when an interrupt is taken or disabled explicitly, and set on return from interrupt or enabled explicitly. A direct write loads the whole byte, as when the register is written as an I/O location. The full byte and each flag on its own wire are driven out for branch and interrupt logic.

Top module: `cpu_status_reg`

## Requirements
- R1: After reset every flag is 0 and the flag byte reads 0x00.
- R2: The flag byte carries, from bit 7 down to bit 0: interrupt enable I, bit-copy T, half carry H, sign S, overflow V, negative N, zero Z, carry C; each single-flag output equals its bit.
- R3: On an ALU update (aluValid high) the flags selected by the mask take Z = (result == 0), N = result bit 7, C = aluCarry and H = aluHalfCarry, visible one clock after the update cycle.
- R4: V follows the operation kind (opKind 0 = logic, 1 = add, 2 = subtract, 3 = logic): logic gives V = 0; add sets V when both operands share a sign and the result sign differs; subtract sets V when the operand signs differ and the result sign differs from opA's sign.
- R5: S is recomputed as N XOR V, using the post-update values, whenever the mask selects N, V or S.
- R6: Mask bit positions are C = 0, Z = 1, N = 2, V = 3, S = 4, H = 5; a flag whose mask bit is 0 keeps its value, and an all-zero mask changes nothing.
- R7: tWrite loads tValue into T; T and I never change on an ALU update.
- R8: irqTaken or ieClear clears I; retiDone or ieSet sets I; when a clear and a set arrive together, clear wins.
- R9: wrEn loads wrData into all eight flags and overrides any ALU update, T write or I command in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| aluValid | input | 1 | ALU result present this cycle |
| opKind | input | 2 | Operation kind: 0 logic, 1 add, 2 subtract, 3 logic |
| opA | input | 8 | First ALU operand |
| opB | input | 8 | Second ALU operand |
| result | input | 8 | ALU result |
| aluCarry | input | 1 | Carry (or borrow) out of bit 7 |
| aluHalfCarry | input | 1 | Carry (or borrow) out of bit 3 |
| flagMask | input | 6 | Per-flag update enable, H S V N Z C at bits 5..0 |
| tWrite | input | 1 | Store a bit into T |
| tValue | input | 1 | Bit stored into T |
| ieSet | input | 1 | Explicit interrupt enable |
| ieClear | input | 1 | Explicit interrupt disable |
| irqTaken | input | 1 | Interrupt accepted, clear I |
| retiDone | input | 1 | Return from interrupt, set I |
| wrEn | input | 1 | Direct write of the full byte |
| wrData | input | 8 | Byte for the direct write |
| flagByte | output | 8 | Full flag register |
| flagI | output | 1 | Interrupt enable |
| flagT | output | 1 | Bit-copy flag |
| flagH | output | 1 | Half carry |
| flagS | output | 1 | Sign, N XOR V |
| flagV | output | 1 | Overflow |
| flagN | output | 1 | Negative |
| flagZ | output | 1 | Zero |
| flagC | output | 1 | Carry |

## Verification
The assertions assume that the result, the carries and the operands stay consistent with one another only as far as this block uses them. No arithmetic identity between them is checked, so any combination is legal stimulus. They also assume that wrData, tValue and the command strobes are valid levels in every cycle after reset. The bench presets the register with a direct write before each table vector, so each expected byte depends on that vector alone. It drives inputs only on falling edges and returns every strobe to 0 after one cycle. Directed cases then cover simultaneous set and clear of I, and a direct write that collides with every other update source.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int FLAG_W = 8;
  localparam int DATA_W = 8;
  localparam int MASK_W = 6;

  localparam int BIT_C = 0;
  localparam int BIT_Z = 1;
  localparam int BIT_N = 2;
  localparam int BIT_V = 3;
  localparam int BIT_S = 4;
  localparam int BIT_H = 5;
  localparam int BIT_T = 6;
  localparam int BIT_I = 7;

  typedef enum logic [1:0] {
    KIND_LOGIC = 2'd0,
    KIND_ADD   = 2'd1,
    KIND_SUB   = 2'd2,
    KIND_PASS  = 2'd3
  } op_kind_e;

  typedef struct packed {
    logic ioWr;
    logic aluUpd;
    logic tWr;
    logic iSet;
    logic iClr;
  } flag_strobe_t;
endpackage

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import flag_pkg::*;
(
  input  logic         aluValid,
  input  logic         tWrite,
  input  logic         ieSet,
  input  logic         ieClear,
  input  logic         irqTaken,
  input  logic         retiDone,
  input  logic         wrEn,
  output flag_strobe_t strobe
);
  logic clrReq;
  logic setReq;

  always_comb begin
    clrReq        = ieClear | irqTaken;
    setReq        = ieSet | retiDone;
    strobe.ioWr   = wrEn;
    strobe.aluUpd = aluValid & ~wrEn;
    strobe.tWr    = tWrite & ~wrEn;
    strobe.iClr   = clrReq & ~wrEn;
    strobe.iSet   = setReq & ~clrReq & ~wrEn;
  end
endmodule

// File: rtl/flag_datapath.sv
module flag_datapath
  import flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  flag_strobe_t      strobe,
  input  logic [1:0]        opKind,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] result,
  input  logic              aluCarry,
  input  logic              aluHalfCarry,
  input  logic [MASK_W-1:0] flagMask,
  input  logic              tValue,
  input  logic [FLAG_W-1:0] wrData,
  output logic [FLAG_W-1:0] flagByte
);
  localparam int MSB = DATA_W - 1;

  logic [FLAG_W-1:0] flagQ;
  logic [FLAG_W-1:0] aluNext;
  logic [FLAG_W-1:0] flagD;
  logic              ovf;
  logic              newN;
  logic              newV;
  logic              signUpd;

  always_comb begin
    unique case (op_kind_e'(opKind))
      KIND_ADD: ovf = (opA[MSB] == opB[MSB]) && (result[MSB] != opA[MSB]);
      KIND_SUB: ovf = (opA[MSB] != opB[MSB]) && (result[MSB] != opA[MSB]);
      default:  ovf = 1'b0;
    endcase
  end

  always_comb begin
    aluNext = flagQ;
    if (flagMask[BIT_C]) aluNext[BIT_C] = aluCarry;
    if (flagMask[BIT_Z]) aluNext[BIT_Z] = (result == '0);
    if (flagMask[BIT_H]) aluNext[BIT_H] = aluHalfCarry;
    newN = flagMask[BIT_N] ? result[MSB] : flagQ[BIT_N];
    newV = flagMask[BIT_V] ? ovf : flagQ[BIT_V];
    aluNext[BIT_N] = newN;
    aluNext[BIT_V] = newV;
    signUpd = flagMask[BIT_N] | flagMask[BIT_V] | flagMask[BIT_S];
    if (signUpd) aluNext[BIT_S] = newN ^ newV;
  end

  always_comb begin
    flagD = flagQ;
    if (strobe.ioWr) begin
      flagD = wrData;
    end else begin
      if (strobe.aluUpd) flagD[BIT_H:BIT_C] = aluNext[BIT_H:BIT_C];
      if (strobe.tWr) flagD[BIT_T] = tValue;
      if (strobe.iClr) flagD[BIT_I] = 1'b0;
      else if (strobe.iSet) flagD[BIT_I] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= flagD;
  end

  assign flagByte = flagQ;

  p_io_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ioWr |=> flagByte == $past(wrData));

  p_sign_rule_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.aluUpd && (flagMask[BIT_N] || flagMask[BIT_V]))
      |=> flagByte[BIT_S] == (flagByte[BIT_N] ^ flagByte[BIT_V]));

  p_carry_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.ioWr && !flagMask[BIT_C]) |=> $stable(flagByte[BIT_C]));

  p_t_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.ioWr && !strobe.tWr) |=> $stable(flagByte[BIT_T]));

  p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.iClr |=> !flagByte[BIT_I]);

  p_zero_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.aluUpd && flagMask[BIT_Z]) |=> flagByte[BIT_Z] == ($past(result) == '0));
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
  import flag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        aluValid,
  input  logic [1:0]  opKind,
  input  logic [7:0]  opA,
  input  logic [7:0]  opB,
  input  logic [7:0]  result,
  input  logic        aluCarry,
  input  logic        aluHalfCarry,
  input  logic [5:0]  flagMask,
  input  logic        tWrite,
  input  logic        tValue,
  input  logic        ieSet,
  input  logic        ieClear,
  input  logic        irqTaken,
  input  logic        retiDone,
  input  logic        wrEn,
  input  logic [7:0]  wrData,
  output logic [7:0]  flagByte,
  output logic        flagI,
  output logic        flagT,
  output logic        flagH,
  output logic        flagS,
  output logic        flagV,
  output logic        flagN,
  output logic        flagZ,
  output logic        flagC
);
  flag_strobe_t strobe;

  flag_ctrl uCtrl (
    .aluValid (aluValid),
    .tWrite   (tWrite),
    .ieSet    (ieSet),
    .ieClear  (ieClear),
    .irqTaken (irqTaken),
    .retiDone (retiDone),
    .wrEn     (wrEn),
    .strobe   (strobe)
  );

  flag_datapath uPath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .opKind       (opKind),
    .opA          (opA),
    .opB          (opB),
    .result       (result),
    .aluCarry     (aluCarry),
    .aluHalfCarry (aluHalfCarry),
    .flagMask     (flagMask),
    .tValue       (tValue),
    .wrData       (wrData),
    .flagByte     (flagByte)
  );

  assign flagI = flagByte[BIT_I];
  assign flagT = flagByte[BIT_T];
  assign flagH = flagByte[BIT_H];
  assign flagS = flagByte[BIT_S];
  assign flagV = flagByte[BIT_V];
  assign flagN = flagByte[BIT_N];
  assign flagZ = flagByte[BIT_Z];
  assign flagC = flagByte[BIT_C];
endmodule

// File: tb/cpu_status_reg_test.sv
module cpu_status_reg_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       aluValid = 1'b0;
  logic [1:0] opKind = 2'd0;
  logic [7:0] opA = 8'h00, opB = 8'h00, result = 8'h00;
  logic       aluCarry = 1'b0, aluHalfCarry = 1'b0;
  logic [5:0] flagMask = 6'h00;
  logic       tWrite = 1'b0, tValue = 1'b0;
  logic       ieSet = 1'b0, ieClear = 1'b0, irqTaken = 1'b0, retiDone = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] flagByte;
  logic       flagI, flagT, flagH, flagS, flagV, flagN, flagZ, flagC;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cpu_status_reg uut (
    .clk(clk), .rstN(rstN), .aluValid(aluValid), .opKind(opKind),
    .opA(opA), .opB(opB), .result(result), .aluCarry(aluCarry),
    .aluHalfCarry(aluHalfCarry), .flagMask(flagMask), .tWrite(tWrite),
    .tValue(tValue), .ieSet(ieSet), .ieClear(ieClear), .irqTaken(irqTaken),
    .retiDone(retiDone), .wrEn(wrEn), .wrData(wrData), .flagByte(flagByte),
    .flagI(flagI), .flagT(flagT), .flagH(flagH), .flagS(flagS),
    .flagV(flagV), .flagN(flagN), .flagZ(flagZ), .flagC(flagC)
  );

  typedef struct packed {
    logic [7:0] preset;
    logic [1:0] kind;
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] res;
    logic       c;
    logic       h;
    logic [5:0] mask;
    logic [7:0] expect_;
    logic [7:0] req;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 2'd1, 8'h7F, 8'h01, 8'h80, 1'b0, 1'b1, 6'h3F, 8'h2C, 8'd4},
    '{8'h00, 2'd1, 8'h80, 8'h80, 8'h00, 1'b1, 1'b0, 6'h3F, 8'h1B, 8'd4},
    '{8'h00, 2'd2, 8'h80, 8'h01, 8'h7F, 1'b0, 1'b1, 6'h3F, 8'h38, 8'd4},
    '{8'h00, 2'd2, 8'h05, 8'h05, 8'h00, 1'b0, 1'b0, 6'h3F, 8'h02, 8'd3},
    '{8'hFF, 2'd0, 8'h0F, 8'hF0, 8'h00, 1'b0, 1'b0, 6'h1E, 8'hE3, 8'd6},
    '{8'hC0, 2'd1, 8'h01, 8'h01, 8'h02, 1'b1, 1'b0, 6'h01, 8'hC1, 8'd6},
    '{8'h04, 2'd0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 6'h08, 8'h14, 8'd5},
    '{8'h00, 2'd2, 8'h01, 8'h02, 8'hFF, 1'b1, 1'b1, 6'h3F, 8'h35, 8'd3},
    '{8'h3F, 2'd0, 8'h00, 8'h00, 8'h80, 1'b1, 1'b1, 6'h00, 8'h3F, 8'd6},
    '{8'h08, 2'd2, 8'h7F, 8'hFF, 8'h80, 1'b0, 1'b0, 6'h04, 8'h0C, 8'd5}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic directWrite(input logic [7:0] v);
    @(negedge clk);
    wrEn = 1'b1; wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic clearStrobes();
    aluValid = 1'b0; tWrite = 1'b0; ieSet = 1'b0; ieClear = 1'b0;
    irqTaken = 1'b0; retiDone = 1'b0; wrEn = 1'b0;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", flagByte, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", flagByte, 8'h00);

    // Table: preset, then one ALU update (R3 R4 R5 R6)
    for (int i = 0; i < NVEC; i++) begin
      directWrite(VECS[i].preset);
      opKind = VECS[i].kind; opA = VECS[i].a; opB = VECS[i].b;
      result = VECS[i].res; aluCarry = VECS[i].c; aluHalfCarry = VECS[i].h;
      flagMask = VECS[i].mask; aluValid = 1'b1;
      @(negedge clk);
      aluValid = 1'b0;
      check($sformatf("R%0d vec%0d", VECS[i].req, i), flagByte, VECS[i].expect_);
    end

    // R2 bit layout via single outputs
    directWrite(8'hA5);
    check("R2 layout", {flagI, flagT, flagH, flagS, flagV, flagN, flagZ, flagC}, 8'hA5);
    check("R2 byte", flagByte, 8'hA5);

    // R7 T store, then ALU update leaves T and I alone
    directWrite(8'h80);
    tWrite = 1'b1; tValue = 1'b1;
    @(negedge clk);
    clearStrobes();
    check("R7 t store", flagByte, 8'hC0);
    opKind = 2'd0; result = 8'h00; aluCarry = 1'b0; aluHalfCarry = 1'b0;
    flagMask = 6'h3F; aluValid = 1'b1;
    @(negedge clk);
    clearStrobes();
    check("R7 t kept on alu", flagByte, 8'hC2);
    tWrite = 1'b1; tValue = 1'b0;
    @(negedge clk);
    clearStrobes();
    check("R7 t cleared", flagByte, 8'h82);

    // R8 interrupt enable commands
    directWrite(8'h00);
    ieSet = 1'b1;
    @(negedge clk); clearStrobes();
    check("R8 ieSet", flagByte, 8'h80);
    irqTaken = 1'b1;
    @(negedge clk); clearStrobes();
    check("R8 irqTaken", flagByte, 8'h00);
    retiDone = 1'b1;
    @(negedge clk); clearStrobes();
    check("R8 retiDone", flagByte, 8'h80);
    ieClear = 1'b1;
    @(negedge clk); clearStrobes();
    check("R8 ieClear", flagByte, 8'h00);
    directWrite(8'h80);
    ieSet = 1'b1; ieClear = 1'b1;
    @(negedge clk); clearStrobes();
    check("R8 clear wins ie", flagByte, 8'h00);
    retiDone = 1'b1; irqTaken = 1'b1;
    @(negedge clk); clearStrobes();
    check("R8 clear wins irq", flagByte, 8'h00);

    // R9 direct write overrides everything in the same cycle
    directWrite(8'h00);
    wrEn = 1'b1; wrData = 8'h55;
    aluValid = 1'b1; flagMask = 6'h3F; result = 8'h00; aluCarry = 1'b0;
    tWrite = 1'b1; tValue = 1'b0; ieSet = 1'b1;
    @(negedge clk); clearStrobes();
    check("R9 priority", flagByte, 8'h55);
    wrEn = 1'b1; wrData = 8'hAA; irqTaken = 1'b1; tWrite = 1'b1; tValue = 1'b0;
    @(negedge clk); clearStrobes();
    check("R9 priority irq", flagByte, 8'hAA);

    // R1 reset again from a non-zero state
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reassert", flagByte, 8'h00);
    rstN = 1'b1;

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule